// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits on the path from a protocol controller's transmit-data line to the enable of a two-wire differential bus driver. The transmit line is active low: a low level asks for a dominant bit, and a high level leaves the bus recessive. In normal mode the guard passes that request straight to the driver as a dominant command. While the request is passed, the guard counts how many clock cycles the line has been held low without a break.

If the low level lasts for a configured number of cycles, the guard stops the dominant command and raises a timeout flag. This keeps a stuck or faulty controller from holding the bus dominant and blocking every other node. The fault does not clear after a set time. It clears only when the transmit line is seen high, or when the block leaves normal mode. So a line that stays stuck low keeps the bus recessive for as long as it stays stuck. When normal mode is off (standby), the transmit line has no effect and the command stays recessive.

The limit is a parameter in clock cycles. A second parameter removes the guard at build time, which leaves a plain gated pass-through.

Top module: `txg_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tmo_flag` is 0 and the low-run count is zero. A low run that starts right after reset gets the full window of `LIMIT_CYC` cycles.
- R2: With `norm_en`=1, `drv_dom` is the inverse of `txd` in the same cycle: `txd`=0 gives 1 (dominant) and `txd`=1 gives 0 (recessive). This holds as long as the guard has not tripped.
- R3: With `norm_en`=0 (standby), `drv_dom` is 0 whatever `txd` does.
- R4: In normal mode with the guard enabled, a run of `txd`=0 keeps `drv_dom`=1 for exactly `LIMIT_CYC` rising clock edges. After the `LIMIT_CYC`-th such edge, `drv_dom` is 0 and `tmo_flag` is 1.
- R5: Once tripped, `tmo_flag` stays 1 and `drv_dom` stays 0 for as long as `txd` stays 0 in normal mode, however long that is.
- R6: The first rising edge that samples `txd`=1 clears `tmo_flag`. The next low run then gets the full `LIMIT_CYC` window again.
- R7: The low-run count restarts whenever `txd` is sampled high. A run of `LIMIT_CYC`-1 low cycles, then one high cycle, then a new low run, does not trip until the new run reaches `LIMIT_CYC` edges.
- R8: A rising edge with `norm_en`=0 clears both the count and the trip. Going back to normal mode with `txd` still 0 drives dominant again for a full window.
- R9: With `GUARD_EN`=0, `drv_dom` equals `norm_en & ~txd` for any run length, and `tmo_flag` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| norm_en | input | 1 | 1 = normal mode, 0 = standby |
| txd | input | 1 | Transmit data from the controller, 0 = dominant request |
| drv_dom | output | 1 | Command to the bus driver, 1 = drive dominant |
| tmo_flag | output | 1 | 1 while the dominant timeout holds the driver off |

## Verification
Some properties are checked on every cycle:
- The driver is never commanded dominant in standby, while `txd` is high, or while the flag is set.
- The flag only rises after a low sample in normal mode.
- The flag clears one edge after a high sample or a standby sample.
- A separate run counter shows that the dominant command ends exactly at the window limit, neither earlier nor later.

Other behaviour needs the bench's scenarios:
- The exact cycle-by-cycle shape of every run length swept around the limit.
- The fresh window after a restart, after a recovery and after a standby visit.
- A trip that is held indefinitely.
- The unguarded build variant.

// File: rtl/txg_pkg.sv
`timescale 1ns/1ps
package txg_pkg;

    typedef enum logic {
        GRD_PASS = 1'b0,
        GRD_TRIP = 1'b1
    } grd_state_e;

    typedef struct packed {
        logic active;   // normal mode selected
        logic dom_req;  // controller asks for dominant
    } tx_req_s;

    function automatic int cnt_width(input int lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/txg_low_timer.sv
`timescale 1ns/1ps
module txg_low_timer #(
    parameter int LIMIT_CYC = 250000,
    parameter int CW        = txg_pkg::cnt_width(LIMIT_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [CW-1:0] count,
    output logic          expire
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT_CYC - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT_CYC);

    // expire: this edge completes the LIMIT_CYC-th low sample
    assign expire = run && (count >= LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
        end else if (count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/txg_trip_state.sv
`timescale 1ns/1ps
module txg_trip_state (
    input  logic clk,
    input  logic rst,
    input  logic release_i,
    input  logic trip_i,
    output logic tripped
);
    import txg_pkg::*;

    grd_state_e state_q;
    grd_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRD_PASS: if (trip_i)    state_d = GRD_TRIP;
            GRD_TRIP: if (release_i) state_d = GRD_PASS;
            default:                 state_d = GRD_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GRD_PASS;
        else     state_q <= state_d;
    end

    assign tripped = (state_q == GRD_TRIP);
endmodule

// File: rtl/txg_guard.sv
`timescale 1ns/1ps
module txg_guard #(
    parameter int LIMIT_CYC = 250000,
    parameter bit GUARD_EN  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic norm_en,
    input  logic txd,
    output logic drv_dom,
    output logic tmo_flag
);
    import txg_pkg::*;

    localparam int CW = cnt_width(LIMIT_CYC);

    tx_req_s req;
    assign req.active  = norm_en;
    assign req.dom_req = ~txd;

    logic want_dom;
    assign want_dom = req.active & req.dom_req;

    generate
        if (GUARD_EN) begin : g_guard
            logic [CW-1:0] low_cnt;
            logic          expire;
            logic          tripped;

            txg_low_timer #(.LIMIT_CYC(LIMIT_CYC), .CW(CW)) u_timer (
                .clk    (clk),
                .rst    (rst),
                .run    (want_dom),
                .count  (low_cnt),
                .expire (expire)
            );

            txg_trip_state u_trip (
                .clk       (clk),
                .rst       (rst),
                .release_i (~want_dom),
                .trip_i    (expire),
                .tripped   (tripped)
            );

            assign drv_dom  = want_dom & ~tripped;
            assign tmo_flag = tripped;
        end else begin : g_pass
            assign drv_dom  = want_dom;
            assign tmo_flag = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/txg_guard_chk.sv
`timescale 1ns/1ps
module txg_guard_chk #(
    parameter int LIMIT_CYC = 250000,
    parameter bit GUARD_EN  = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic norm_en,
    input logic txd,
    input logic drv_dom,
    input logic tmo_flag
);
    localparam int RW = txg_pkg::cnt_width(LIMIT_CYC);
    localparam logic [RW-1:0] TOP = RW'(LIMIT_CYC);

    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst || !norm_en || txd) run_q <= '0;
        else if (run_q != TOP)      run_q <= run_q + 1'b1;
    end

    assert_standby_recessive_R3: assert property (@(posedge clk) disable iff (rst)
        !norm_en |-> !drv_dom);

    assert_high_recessive_R2: assert property (@(posedge clk) disable iff (rst)
        txd |-> !drv_dom);

    generate
        if (GUARD_EN) begin : g_chk
            assert_flag_blocks_R5: assert property (@(posedge clk) disable iff (rst)
                tmo_flag |-> !drv_dom);

            assert_flag_cause_R4: assert property (@(posedge clk) disable iff (rst)
                $rose(tmo_flag) |-> $past(norm_en && !txd));

            assert_release_R6: assert property (@(posedge clk) disable iff (rst)
                (norm_en && txd) |=> !tmo_flag);

            assert_standby_clear_R8: assert property (@(posedge clk) disable iff (rst)
                !norm_en |=> !tmo_flag);

            assert_window_end_R4: assert property (@(posedge clk) disable iff (rst)
                drv_dom |-> (run_q < TOP));

            assert_window_full_R7: assert property (@(posedge clk) disable iff (rst)
                (norm_en && !txd && run_q < TOP) |-> drv_dom);
        end else begin : g_chk_pt
            assert_no_flag_R9: assert property (@(posedge clk) disable iff (rst)
                !tmo_flag);

            assert_pass_R9: assert property (@(posedge clk) disable iff (rst)
                drv_dom == (norm_en && !txd));
        end
    endgenerate
endmodule

bind txg_guard txg_guard_chk #(.LIMIT_CYC(LIMIT_CYC), .GUARD_EN(GUARD_EN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .norm_en  (norm_en),
    .txd      (txd),
    .drv_dom  (drv_dom),
    .tmo_flag (tmo_flag)
);

// File: tb/txg_guard_tb.sv
`timescale 1ns/1ps
module txg_guard_tb;
    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic norm_en = 1'b0;
    logic txd = 1'b1;
    logic drv_dom, tmo_flag, drv_pt, flag_pt;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    txg_guard #(.LIMIT_CYC(LIM), .GUARD_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .norm_en(norm_en), .txd(txd),
        .drv_dom(drv_dom), .tmo_flag(tmo_flag));

    txg_guard #(.LIMIT_CYC(LIM), .GUARD_EN(1'b0)) u_dut_pt (
        .clk(clk), .rst(rst), .norm_en(norm_en), .txd(txd),
        .drv_dom(drv_pt), .tmo_flag(flag_pt));

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // drive at the falling edge, sample 1 ns later
    task automatic drive(input logic n, input logic t);
        @(negedge clk);
        norm_en = n;
        txd = t;
        #1;
    endtask

    // a low run of len cycles from a clean state, then n_high high cycles
    task automatic low_run(input int len, input int n_high);
        for (int k = 0; k < len; k++) begin
            drive(1'b1, 1'b0);
            chk("R4 drv", drv_dom, k < LIM);
            chk("R4 flag", tmo_flag, k >= LIM);
            chk("R9 pass drv", drv_pt, 1'b1);
            chk("R9 pass flag", flag_pt, 1'b0);
        end
        for (int h = 0; h < n_high; h++) begin
            drive(1'b1, 1'b1);
            chk("R2 high recessive", drv_dom, 1'b0);
            chk("R6 flag at release", tmo_flag, (h == 0) && (len >= LIM));
            chk("R9 pass high", drv_pt, 1'b0);
        end
    endtask

    initial begin
        // R1: state during reset and right after it
        drive(1'b1, 1'b1);
        chk("R1 flag in reset", tmo_flag, 1'b0);
        drive(1'b1, 1'b1);
        rst = 1'b0;
        #1;
        chk("R1 flag after reset", tmo_flag, 1'b0);
        low_run(LIM + 1, 2);           // R1: full window right after reset

        // R2, R4, R6, R9: sweep of run lengths around the limit
        for (int len = 1; len <= LIM + 4; len++) low_run(len, 2);

        // R7: restart after a single high cycle
        low_run(LIM - 1, 1);
        low_run(LIM + 1, 2);

        // R5: a trip held for a long stuck-low run
        low_run(LIM + 40, 2);

        // R3: standby ignores txd
        for (int k = 0; k < 12; k++) begin
            drive(1'b0, k[0]);
            chk("R3 standby drv", drv_dom, 1'b0);
            chk("R3 standby flag", tmo_flag, 1'b0);
            chk("R9 standby pass", drv_pt, 1'b0);
        end

        // R8: trip, drop to standby with txd low, come back still low
        drive(1'b1, 1'b1);
        for (int k = 0; k < LIM + 2; k++) drive(1'b1, 1'b0);
        chk("R8 tripped before standby", tmo_flag, 1'b1);
        drive(1'b0, 1'b0);
        chk("R8 standby drv", drv_dom, 1'b0);
        drive(1'b0, 1'b0);
        chk("R8 flag cleared by standby", tmo_flag, 1'b0);
        low_run(LIM + 2, 2);           // a fresh full window

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule